// File: doc/BRIEF.md
# Mirrored Configuration Register Checker

This block holds four 10-bit configuration words (a fault-enable word, a lower threshold, an upper threshold and an input-range selector). Each word has a shadow copy that software programs with a separate write. Every clock cycle, comparators check each configuration word against its shadow. A difference on any bit of any pair sets a sticky mismatch flag. Software clears that flag by reading the flags word once all pairs agree.

A fault output follows the mismatch flag, but only while the mismatch-enable bit of the fault-enable word is set. The reset values of each pair are bitwise complements of each other. As a result, the fault is active out of reset and stays active until software has written matching values into both copies of every pair and has read the flags word.

A build-time option removes the input-range pair from use. In that variant the range shadow is read-only with the constant 0x0C0, the range word reads zero, and the pair takes no part in the comparison.

Top module: `cfg_mirror_chk`

## Requirements
- R1: After reset the configuration words at addresses 0x08 (fault-enable), 0x09 (lower), 0x0A (upper) and 0x0B (range) read 0x3FF, 0x100, 0x200 and 0x0C0. Their shadows at 0x13, 0x14, 0x15 and 0x16 read 0x000, 0x2FF, 0x1FF and 0x33F.
- R2: A write with wrEn high stores wrData into the addressed word, which reads back unchanged. A write to a shadow leaves its configuration word unchanged, and a write to a configuration word leaves its shadow unchanged.
- R3: The comparison runs every cycle without any trigger. Any bit difference in any pair sets the mismatch flag (mvFlag, bit 0 of the flags word at 0x18) by the clock edge after the difference appears.
- R4: The mismatch flag is sticky. It stays set after the pairs come back into agreement, and a flags read taken while any pair differs does not clear it.
- R5: A flags read (rdEn high, addr 0x18) returns the flag state before the clear. It clears the flag at that clock edge if all pairs agree in that cycle.
- R6: fault equals the registered mismatch flag ANDed with bit 9 (mismatch enable) of the fault-enable word, so fault follows a mismatch within one cycle of the flag.
- R7: Out of reset the mismatch flag is set and fault is asserted.
- R8: Reads return the stored 10-bit value zero-extended to the 16-bit read bus. Unmapped addresses read zero.
- R9: With FIXED_RANGE=1 the range shadow reads 0x0C0 and ignores writes, the range word reads zero and ignores writes, and the range pair never sets the mismatch flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| addr | input | 5 | Register address for reads and writes |
| wrEn | input | 1 | Write strobe |
| wrData | input | 10 | Write data |
| rdEn | input | 1 | Read strobe; a read of the flags word may clear the mismatch flag |
| rdData | output | 16 | Read data for the addressed word, combinational |
| mvFlag | output | 1 | Sticky mismatch flag |
| fault | output | 1 | Fault output: mismatch flag gated by the mismatch-enable bit |

## Verification
A stored word that is corrupted inside the block does not wait for a read to show itself. It raises mvFlag at the next clock edge, and raises fault in the same cycle whenever the enable bit is set. A read of that address shows the wrong value at once, because the read path is combinational. A flag that clears too early or fails to clear shows up in the flags word on the read that follows. A decoder that writes the wrong copy shows up as a mismatch, and as a read-back that differs from the value written.

// File: rtl/cfg_mirror_pkg.sv
package cfg_mirror_pkg;

  localparam int CFG_W     = 10;
  localparam int NUM_PAIRS = 4;

  // pair index order
  localparam int IDX_FE  = 0;
  localparam int IDX_LO  = 1;
  localparam int IDX_HI  = 2;
  localparam int IDX_RNG = 3;

  typedef logic [CFG_W-1:0] cfgWord_t;

  // configuration word reset values; shadows reset to the complement
  localparam cfgWord_t PRI_RST [NUM_PAIRS] = '{10'h3FF, 10'h100, 10'h200, 10'h0C0};
  localparam cfgWord_t FIXED_RNG_SHADOW = 10'h0C0;

  typedef struct packed {
    logic [NUM_PAIRS-1:0] wrPri;
    logic [NUM_PAIRS-1:0] wrVer;
    logic [NUM_PAIRS-1:0] selPri;
    logic [NUM_PAIRS-1:0] selVer;
    logic                 selFlags;
    logic                 rdFlags;
  } strobe_t;

endpackage

// File: rtl/cfg_mirror_ctrl.sv
module cfg_mirror_ctrl
  import cfg_mirror_pkg::*;
#(
  parameter int ADDR_W      = 5,
  parameter int PRI_BASE    = 'h08,
  parameter int VER_BASE    = 'h13,
  parameter int FLAG_ADDR   = 'h18,
  parameter bit FIXED_RANGE = 1'b0
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic              rdEn,
  output strobe_t           strb
);

  logic [NUM_PAIRS-1:0] priHit;
  logic [NUM_PAIRS-1:0] verHit;
  logic [NUM_PAIRS-1:0] verWrOk;

  for (genvar i = 0; i < NUM_PAIRS; i++) begin : g_dec
    if (FIXED_RANGE && i == IDX_RNG) begin : g_fixed
      // range pair unused: configuration word unmapped, shadow read-only
      assign priHit[i]  = 1'b0;
      assign verHit[i]  = (addr == ADDR_W'(VER_BASE + i));
      assign verWrOk[i] = 1'b0;
    end else begin : g_live
      assign priHit[i]  = (addr == ADDR_W'(PRI_BASE + i));
      assign verHit[i]  = (addr == ADDR_W'(VER_BASE + i));
      assign verWrOk[i] = 1'b1;
    end
  end

  always_comb begin
    strb          = '0;
    strb.selPri   = priHit;
    strb.selVer   = verHit;
    strb.selFlags = (addr == ADDR_W'(FLAG_ADDR));
    strb.wrPri    = wrEn ? priHit : '0;
    strb.wrVer    = wrEn ? (verHit & verWrOk) : '0;
    strb.rdFlags  = rdEn & strb.selFlags;
  end

endmodule

// File: rtl/cfg_mirror_dp.sv
module cfg_mirror_dp
  import cfg_mirror_pkg::*;
#(
  parameter int RD_W        = 16,
  parameter int EMV_BIT     = 9,
  parameter bit FIXED_RANGE = 1'b0
) (
  input  logic            clk,
  input  logic            rstN,
  input  strobe_t         strb,
  input  cfgWord_t        wrData,
  output logic [RD_W-1:0] rdData,
  output logic            mvFlag,
  output logic            fault
);

  cfgWord_t             priQ [NUM_PAIRS];
  cfgWord_t             verQ [NUM_PAIRS];
  logic [NUM_PAIRS-1:0] misBit;
  logic                 anyMis;
  logic                 mvQ;

  for (genvar i = 0; i < NUM_PAIRS; i++) begin : g_pair
    if (FIXED_RANGE && i == IDX_RNG) begin : g_fixed
      assign priQ[i]   = '0;
      assign verQ[i]   = FIXED_RNG_SHADOW;
      assign misBit[i] = 1'b0;
    end else begin : g_live
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          priQ[i] <= PRI_RST[i];
          verQ[i] <= ~PRI_RST[i];
        end else begin
          if (strb.wrPri[i]) priQ[i] <= wrData;
          if (strb.wrVer[i]) verQ[i] <= wrData;
        end
      end

      // continuous bitwise compare of the pair
      assign misBit[i] = |(priQ[i] ^ verQ[i]);

      // R2
      shadow_write_isolated_chk: assert property (@(posedge clk) disable iff (!rstN)
        strb.wrVer[i] |=> $stable(priQ[i]));
      // R2
      primary_write_isolated_chk: assert property (@(posedge clk) disable iff (!rstN)
        strb.wrPri[i] |=> $stable(verQ[i]));
    end
  end

  assign anyMis = |misBit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             mvQ <= 1'b1;
    else if (anyMis)       mvQ <= 1'b1;
    else if (strb.rdFlags) mvQ <= 1'b0;
  end

  assign mvFlag = mvQ;
  assign fault  = mvQ & priQ[IDX_FE][EMV_BIT];

  always_comb begin
    rdData = '0;
    for (int i = 0; i < NUM_PAIRS; i++) begin
      if (strb.selPri[i]) rdData = rdData | RD_W'(priQ[i]);
      if (strb.selVer[i]) rdData = rdData | RD_W'(verQ[i]);
    end
    if (strb.selFlags) rdData = rdData | RD_W'(mvQ);
  end

  // R3
  mismatch_sets_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    anyMis |=> mvQ);
  // R5
  flag_clear_needs_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(mvQ) |-> $past(strb.rdFlags));
  // R4
  flag_clear_needs_match_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(mvQ) |-> !$past(anyMis));

endmodule

// File: rtl/cfg_mirror_chk.sv
module cfg_mirror_chk
  import cfg_mirror_pkg::*;
#(
  parameter int ADDR_W      = 5,
  parameter int RD_W        = 16,
  parameter int EMV_BIT     = 9,
  parameter bit FIXED_RANGE = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic [CFG_W-1:0]  wrData,
  input  logic              rdEn,
  output logic [RD_W-1:0]   rdData,
  output logic              mvFlag,
  output logic              fault
);

  strobe_t strb;

  cfg_mirror_ctrl #(
    .ADDR_W      (ADDR_W),
    .FIXED_RANGE (FIXED_RANGE)
  ) i_ctrl (
    .addr (addr),
    .wrEn (wrEn),
    .rdEn (rdEn),
    .strb (strb)
  );

  cfg_mirror_dp #(
    .RD_W        (RD_W),
    .EMV_BIT     (EMV_BIT),
    .FIXED_RANGE (FIXED_RANGE)
  ) i_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .wrData (wrData),
    .rdData (rdData),
    .mvFlag (mvFlag),
    .fault  (fault)
  );

  // R6
  fault_implies_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    fault |-> mvFlag);

endmodule

// File: tb/test_cfg_mirror_chk.sv
module test_cfg_mirror_chk;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [4:0]  addr = '0;
  logic        wrEn = 1'b0;
  logic [9:0]  wrData = '0;
  logic        rdEn = 1'b0;
  logic [15:0] rdData, rdDataFx;
  logic        mvFlag, fault, mvFx, faultFx;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  cfg_mirror_chk i_cfg_mirror_chk (
    .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .wrData(wrData),
    .rdEn(rdEn), .rdData(rdData), .mvFlag(mvFlag), .fault(fault)
  );

  cfg_mirror_chk #(.FIXED_RANGE(1'b1)) i_cfg_mirror_chk_fixed (
    .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .wrData(wrData),
    .rdEn(rdEn), .rdData(rdDataFx), .mvFlag(mvFx), .fault(faultFx)
  );

  // {address, write data}; the read-back must equal the write data
  localparam logic [14:0] VEC_TAB [6] = '{
    {5'h13, 10'h3FF}, {5'h14, 10'h100}, {5'h15, 10'h200},
    {5'h16, 10'h0C0}, {5'h09, 10'h155}, {5'h14, 10'h155}
  };

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic doWrite(input logic [4:0] a, input logic [9:0] d);
    @(negedge clk);
    addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
    @(negedge clk);
  endtask

  task automatic readReg(input logic [4:0] a, output logic [15:0] v, output logic [15:0] vFx);
    @(negedge clk);
    addr = a; rdEn = 1'b0;
    #1 v = rdData; vFx = rdDataFx;
  endtask

  task automatic readFlags(output logic [15:0] v);
    @(negedge clk);
    addr = 5'h18; rdEn = 1'b1;
    #1 v = rdData;
    @(negedge clk);
    rdEn = 1'b0;
    #1;
  endtask

  initial begin
    #(4 * 100000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got 0x0 expected 0x1");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] v, vFx;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk); #1;

    // R7 reset state
    chk("R7 mvFlag", 16'(mvFlag), 16'h1);
    chk("R7 fault", 16'(fault), 16'h1);
    // R1 reset values
    readReg(5'h08, v, vFx); chk("R1 fe", v, 16'h3FF);
    readReg(5'h09, v, vFx); chk("R1 lo", v, 16'h100);
    readReg(5'h0A, v, vFx); chk("R1 hi", v, 16'h200);
    readReg(5'h0B, v, vFx); chk("R1 rng", v, 16'h0C0);
    chk("R9 fixed rng word", vFx, 16'h0);
    readReg(5'h13, v, vFx); chk("R1 fe shadow", v, 16'h000);
    readReg(5'h14, v, vFx); chk("R1 lo shadow", v, 16'h2FF);
    readReg(5'h15, v, vFx); chk("R1 hi shadow", v, 16'h1FF);
    readReg(5'h16, v, vFx); chk("R1 rng shadow", v, 16'h33F);
    chk("R9 fixed rng shadow", vFx, 16'h0C0);

    // R2 table of writes with read-back
    for (int k = 0; k < 6; k++) begin
      doWrite(VEC_TAB[k][14:10], VEC_TAB[k][9:0]);
      readReg(VEC_TAB[k][14:10], v, vFx);
      chk("R2 readback", v, 16'(VEC_TAB[k][9:0]));
    end

    // all pairs now agree, but the flag is sticky: R4
    chk("R4 sticky after match", 16'(mvFlag), 16'h1);
    readFlags(v);
    chk("R5 flags read value", v, 16'h0001);
    chk("R5 cleared", 16'(mvFlag), 16'h0);
    chk("R6 fault off", 16'(fault), 16'h0);
    chk("R9 fixed clears without range pair", 16'(mvFx), 16'h0);

    // R3/R6: single-bit difference on the upper threshold
    doWrite(5'h0A, 10'h201);
    chk("R3 mismatch sets flag", 16'(mvFlag), 16'h1);
    chk("R6 fault with enable", 16'(fault), 16'h1);
    readReg(5'h15, v, vFx); chk("R2 shadow untouched", v, 16'h200);

    // R4: read while mismatched does not clear
    readFlags(v);
    chk("R4 read during mismatch", 16'(mvFlag), 16'h1);

    doWrite(5'h15, 10'h201);
    readReg(5'h0A, v, vFx); chk("R2 primary untouched", v, 16'h201);
    readFlags(v);
    chk("R5 cleared after fix", 16'(mvFlag), 16'h0);

    // R6: enable bit off, flag set, fault low
    doWrite(5'h08, 10'h1FF);
    chk("R6 flag set enable off", 16'(mvFlag), 16'h1);
    chk("R6 fault masked", 16'(fault), 16'h0);
    doWrite(5'h13, 10'h1FF);
    readFlags(v);
    chk("R5 cleared again", 16'(mvFlag), 16'h0);

    // range shadow mismatch: flag up, fault masked; fixed variant ignores
    doWrite(5'h16, 10'h0C1);
    chk("R3 range pair", 16'(mvFlag), 16'h1);
    chk("R6 range fault masked", 16'(fault), 16'h0);
    chk("R9 fixed no flag", 16'(mvFx), 16'h0);
    readReg(5'h16, v, vFx); chk("R9 fixed shadow write ignored", vFx, 16'h0C0);
    doWrite(5'h0B, 10'h0C1);
    readReg(5'h0B, v, vFx); chk("R9 fixed word write ignored", vFx, 16'h0);
    readFlags(v);
    chk("R5 range fixed", 16'(mvFlag), 16'h0);

    // R8 unmapped and zero extension
    readReg(5'h1F, v, vFx); chk("R8 unmapped 1F", v, 16'h0);
    readReg(5'h00, v, vFx); chk("R8 unmapped 00", v, 16'h0);
    readReg(5'h18, v, vFx); chk("R8 flags zero-extended", v, 16'h0);
    readReg(5'h08, v, vFx); chk("R8 zero-extended word", v, 16'h1FF);

    // R6: re-enable with mismatching shadow
    doWrite(5'h08, 10'h3FF);
    chk("R6 re-enabled fault", 16'(fault), 16'h1);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule